// File: doc/BRIEF.md
# Region Permission Checker for a Memory Port

This block sits in front of one memory port whose address space is cut into a fixed number of equal regions, each with its own permission word. Every transfer presented to the port is judged in the cycle it is issued: its region is taken from the upper address bits, and its kind (data read, data write or instruction fetch) and its security attribute are compared against that region's permissions. An allowed transfer is passed on to the memory through its read or write strobe. A blocked transfer never reaches the memory: a blocked read returns zero and a blocked write changes nothing.

One cycle after the transfer, in its response phase, the block reports the outcome. Faults are routed by the kind of master. A processor-type master that breaks a security rule gets a secure-fault pulse. A processor-type master that breaks a read, write or execute rule gets a bus-fault pulse and also latches the sticky access-error event. Every other master gets no fault pulse, only the blocked transfer and the event. Software controls the permission words, which can be frozen until reset, the event flag and the interrupt enable through a small word-indexed register port.

One instance serves one memory. The region size is a parameter, so the same block serves a large code store with big regions and a smaller data store with finer ones.

Top module: `rgn_guard`

## Requirements
- R1: After reset every permission word reads 0x17 (execute at bit 0, write at bit 1, read at bit 2, secure at bit 4, lock at bit 8; other bits read 0); the event flag (index 64), the interrupt enable (indexes 65 to 67) and `irq` are 0. Index 0 to 63 of the register port selects a region's permission word.
- R2: The region of a transfer is address bits [REGION_SHIFT+5:REGION_SHIFT]. A kind code of 0 (read) needs the read bit, 1 (write) needs the write bit, 2 or 3 (fetch) needs only the execute bit; a fetch succeeds in a region whose read bit is clear.
- R3: A region with its secure bit set blocks any transfer whose `xfer_secure` is 0, whatever its other bits.
- R4: Once a region's lock bit is set, register writes to that region's word are ignored until reset.
- R5: An allowed read or fetch raises `mem_re` and an allowed write raises `mem_we` in the request cycle; a blocked transfer raises neither, and a blocked read or fetch answers `resp_rdata` = 0 in its response cycle.
- R6: A processor-type transfer (`xfer_cpu` = 1) with a security violation gives `sec_fault` and `resp_err` in its response cycle and does not set the event.
- R7: A processor-type transfer with only a read, write or execute violation gives `bus_fault` and `resp_err` and sets the event.
- R8: A transfer with `xfer_cpu` = 0 and any violation gives `resp_err`, sets the event, and gives neither fault pulse.
- R9: A processor-type transfer that breaks the security rule and a permission rule at once gives `sec_fault` only: no `bus_fault`, no event.
- R10: The event (index 64, bit 0) stays set until software writes it with bit 0 = 0; a violation that lands in the same cycle as that write leaves it set.
- R11: Index 65 writes the interrupt enable from bit 0, index 66 sets it when bit 0 is 1, index 67 clears it when bit 0 is 1; all three read the enable. `irq` is the event AND the enable, registered one cycle.
- R12: `resp_valid`, `resp_err`, `sec_fault` and `bus_fault` appear only in the cycle after the transfer's request and last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RIDX_W+1 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| xfer_valid | input | 1 | Transfer request this cycle |
| xfer_addr | input | ADDR_W | Transfer byte address |
| xfer_kind | input | 2 | 0 read, 1 write, 2 or 3 fetch |
| xfer_secure | input | 1 | Transfer carries the secure attribute |
| xfer_cpu | input | 1 | Transfer comes from a processor-type master |
| xfer_allow | output | 1 | Transfer passes all checks |
| mem_re | output | 1 | Read strobe to memory |
| mem_we | output | 1 | Write strobe to memory |
| mem_rdata | input | DATA_W | Data returned by memory in the response cycle |
| resp_valid | output | 1 | Response phase of a transfer |
| resp_rdata | output | DATA_W | Read data to master, zero when blocked |
| resp_err | output | 1 | Bus error to master |
| sec_fault | output | 1 | Secure-fault pulse |
| bus_fault | output | 1 | Bus-fault pulse |
| acc_evt | output | 1 | Sticky access-error event |
| irq | output | 1 | Interrupt request |

## Verification
Two functions meet in one cycle: a hardware violation setting the event and a software write clearing it. The bench drives a blocked transfer from a non-processor master in the very cycle it writes 0 to the event index, then reads the flag and expects it still set, and separately confirms a lone clear does work. The other collision is a processor transfer that breaks both the security and a permission rule, judged by `sec_fault` alone firing with `bus_fault` and the event untouched.

// File: rtl/rgn_guard_pkg.sv
package rgn_guard_pkg;

    typedef enum logic [1:0] {
        ACC_READ      = 2'b00,
        ACC_WRITE     = 2'b01,
        ACC_FETCH     = 2'b10,
        ACC_FETCH_ALT = 2'b11
    } acc_kind_e;

    localparam int unsigned BIT_EX   = 0;
    localparam int unsigned BIT_WR   = 1;
    localparam int unsigned BIT_RD   = 2;
    localparam int unsigned BIT_SEC  = 4;
    localparam int unsigned BIT_LOCK = 8;

    typedef struct packed {
        logic lock;
        logic sec;
        logic rd;
        logic wr;
        logic ex;
    } perm_t;

    localparam perm_t PERM_RESET = '{lock: 1'b0, sec: 1'b1, rd: 1'b1, wr: 1'b1, ex: 1'b1};

    typedef struct packed {
        logic sec_viol;
        logic perm_viol;
        logic allow;
    } verdict_t;

    typedef struct packed {
        logic bus_err;
        logic sec_fault;
        logic bus_fault;
        logic evt_set;
    } route_t;

    // Register word indexes above the region block, relative to the region count
    localparam int unsigned CTL_EVT   = 0;
    localparam int unsigned CTL_IE    = 1;
    localparam int unsigned CTL_IESET = 2;
    localparam int unsigned CTL_IECLR = 3;

    function automatic perm_t unpack_perm(input logic [31:0] w);
        perm_t p;
        p.ex   = w[BIT_EX];
        p.wr   = w[BIT_WR];
        p.rd   = w[BIT_RD];
        p.sec  = w[BIT_SEC];
        p.lock = w[BIT_LOCK];
        return p;
    endfunction

    function automatic logic [31:0] pack_perm(input perm_t p);
        logic [31:0] w;
        w = '0;
        w[BIT_EX]   = p.ex;
        w[BIT_WR]   = p.wr;
        w[BIT_RD]   = p.rd;
        w[BIT_SEC]  = p.sec;
        w[BIT_LOCK] = p.lock;
        return w;
    endfunction

    // Security faults win over permission faults for processor masters
    function automatic route_t route_fault(input verdict_t v, input logic cpu);
        route_t r;
        logic any;
        any         = v.sec_viol | v.perm_viol;
        r.bus_err   = any;
        if (cpu) begin
            r.sec_fault = v.sec_viol;
            r.bus_fault = v.perm_viol & ~v.sec_viol;
            r.evt_set   = v.perm_viol & ~v.sec_viol;
        end else begin
            r.sec_fault = 1'b0;
            r.bus_fault = 1'b0;
            r.evt_set   = any;
        end
        return r;
    endfunction

endpackage

// File: rtl/rgn_perm_file.sv
module rgn_perm_file
    import rgn_guard_pkg::*;
#(
    parameter int unsigned RIDX_W = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [RIDX_W-1:0]  wr_idx,
    input  logic [31:0]        wr_data,
    input  logic [RIDX_W-1:0]  look_idx,
    output perm_t              look_perm,
    input  logic [RIDX_W-1:0]  rd_idx,
    output perm_t              rd_perm
);
    localparam int unsigned NREG = 1 << RIDX_W;

    perm_t [NREG-1:0] perm_vec;

    for (genvar g = 0; g < NREG; g++) begin : g_region
        perm_t perm_q;
        logic  hit;
        assign hit = wr_en && (wr_idx == RIDX_W'(g));
        always_ff @(posedge clk) begin
            if (rst) begin
                perm_q <= PERM_RESET;
            end else if (hit && !perm_q.lock) begin
                perm_q <= unpack_perm(wr_data);
            end
        end
        assign perm_vec[g] = perm_q;
    end

    assign look_perm = perm_vec[look_idx];
    assign rd_perm   = perm_vec[rd_idx];

endmodule

// File: rtl/rgn_access_eval.sv
module rgn_access_eval
    import rgn_guard_pkg::*;
(
    input  logic      valid,
    input  logic [1:0] kind,
    input  logic      secure,
    input  perm_t     perm,
    output verdict_t  verdict
);
    logic need;

    always_comb begin
        unique case (acc_kind_e'(kind))
            ACC_READ:  need = perm.rd;
            ACC_WRITE: need = perm.wr;
            default:   need = perm.ex;
        endcase
        verdict.sec_viol  = valid & perm.sec & ~secure;
        verdict.perm_viol = valid & ~need;
        verdict.allow     = valid & ~verdict.sec_viol & ~verdict.perm_viol;
    end

endmodule

// File: rtl/rgn_resp_stage.sv
module rgn_resp_stage
    import rgn_guard_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     valid,
    input  verdict_t verdict,
    input  logic     cpu,
    input  logic     evt_wr,
    input  logic     evt_wval,
    input  logic     ie_wr,
    input  logic     ie_wval,
    input  logic     ie_set,
    input  logic     ie_clr,
    output logic     resp_valid,
    output logic     resp_allow,
    output logic     resp_err,
    output logic     sec_fault,
    output logic     bus_fault,
    output logic     evt,
    output logic     inten,
    output logic     irq
);
    route_t route;

    assign route = valid ? route_fault(verdict, cpu) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_allow <= 1'b0;
            resp_err   <= 1'b0;
            sec_fault  <= 1'b0;
            bus_fault  <= 1'b0;
            evt        <= 1'b0;
            inten      <= 1'b0;
            irq        <= 1'b0;
        end else begin
            resp_valid <= valid;
            resp_allow <= verdict.allow;
            resp_err   <= route.bus_err;
            sec_fault  <= route.sec_fault;
            bus_fault  <= route.bus_fault;
            // hardware set beats a same-cycle software clear
            if (route.evt_set) begin
                evt <= 1'b1;
            end else if (evt_wr) begin
                evt <= evt_wval;
            end
            if (ie_wr) begin
                inten <= ie_wval;
            end else if (ie_set) begin
                inten <= 1'b1;
            end else if (ie_clr) begin
                inten <= 1'b0;
            end
            irq <= evt & inten;
        end
    end

endmodule

// File: rtl/rgn_guard.sv
module rgn_guard
    import rgn_guard_pkg::*;
#(
    parameter int unsigned RIDX_W       = 6,
    parameter int unsigned REGION_BYTES = 16384,
    parameter int unsigned DATA_W       = 32,
    localparam int unsigned REGION_SHIFT = $clog2(REGION_BYTES),
    localparam int unsigned ADDR_W       = REGION_SHIFT + RIDX_W,
    localparam int unsigned RA_W         = RIDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              xfer_valid,
    input  logic [ADDR_W-1:0] xfer_addr,
    input  logic [1:0]        xfer_kind,
    input  logic              xfer_secure,
    input  logic              xfer_cpu,
    output logic              xfer_allow,
    output logic              mem_re,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              resp_err,
    output logic              sec_fault,
    output logic              bus_fault,
    output logic              acc_evt,
    output logic              irq
);
    logic              in_regions;
    logic [RIDX_W-1:0] reg_idx;
    logic [RIDX_W-1:0] xfer_idx;
    perm_t             look_perm;
    perm_t             rd_perm;
    verdict_t          verdict;
    logic              resp_allow;
    logic              inten;
    logic              evt_wr, ie_wr, ie_set, ie_clr;

    assign in_regions = ~reg_addr[RA_W-1];
    assign reg_idx    = reg_addr[RIDX_W-1:0];
    assign xfer_idx   = xfer_addr[REGION_SHIFT +: RIDX_W];

    assign evt_wr = reg_wr && !in_regions && (reg_idx == RIDX_W'(CTL_EVT));
    assign ie_wr  = reg_wr && !in_regions && (reg_idx == RIDX_W'(CTL_IE));
    assign ie_set = reg_wr && !in_regions && (reg_idx == RIDX_W'(CTL_IESET)) && reg_wdata[0];
    assign ie_clr = reg_wr && !in_regions && (reg_idx == RIDX_W'(CTL_IECLR)) && reg_wdata[0];

    rgn_perm_file #(.RIDX_W(RIDX_W)) u_perm (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr && in_regions),
        .wr_idx    (reg_idx),
        .wr_data   (reg_wdata),
        .look_idx  (xfer_idx),
        .look_perm (look_perm),
        .rd_idx    (reg_idx),
        .rd_perm   (rd_perm)
    );

    rgn_access_eval u_eval (
        .valid   (xfer_valid),
        .kind    (xfer_kind),
        .secure  (xfer_secure),
        .perm    (look_perm),
        .verdict (verdict)
    );

    rgn_resp_stage u_resp (
        .clk        (clk),
        .rst        (rst),
        .valid      (xfer_valid),
        .verdict    (verdict),
        .cpu        (xfer_cpu),
        .evt_wr     (evt_wr),
        .evt_wval   (reg_wdata[0]),
        .ie_wr      (ie_wr),
        .ie_wval    (reg_wdata[0]),
        .ie_set     (ie_set),
        .ie_clr     (ie_clr),
        .resp_valid (resp_valid),
        .resp_allow (resp_allow),
        .resp_err   (resp_err),
        .sec_fault  (sec_fault),
        .bus_fault  (bus_fault),
        .evt        (acc_evt),
        .inten      (inten),
        .irq        (irq)
    );

    assign xfer_allow = verdict.allow;
    assign mem_we     = verdict.allow && (acc_kind_e'(xfer_kind) == ACC_WRITE);
    assign mem_re     = verdict.allow && (acc_kind_e'(xfer_kind) != ACC_WRITE);
    assign resp_rdata = resp_allow ? mem_rdata : '0;

    always_comb begin
        reg_rdata = '0;
        if (in_regions) begin
            reg_rdata = pack_perm(rd_perm);
        end else begin
            if (reg_idx == RIDX_W'(CTL_EVT)) begin
                reg_rdata[0] = acc_evt;
            end else if (reg_idx == RIDX_W'(CTL_IE) || reg_idx == RIDX_W'(CTL_IESET) ||
                         reg_idx == RIDX_W'(CTL_IECLR)) begin
                reg_rdata[0] = inten;
            end
        end
    end

endmodule

// File: rtl/rgn_guard_chk.sv
module rgn_guard_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned RA_W   = 7,
    parameter int unsigned NREG   = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              xfer_valid,
    input logic [1:0]        xfer_kind,
    input logic              mem_we,
    input logic              reg_wr,
    input logic [RA_W-1:0]   reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              resp_err,
    input logic [DATA_W-1:0] resp_rdata,
    input logic              sec_fault,
    input logic              bus_fault,
    input logic              acc_evt,
    input logic              irq
);
    logic evt_clear_wr;
    assign evt_clear_wr = reg_wr && (reg_addr == RA_W'(NREG)) && !reg_wdata[0];

    // R9: secure fault excludes bus fault
    assert_fault_precedence_R9: assert property (@(posedge clk) disable iff (rst)
        sec_fault |-> !bus_fault);

    // R5: a blocked response carries zero data
    assert_blocked_zero_R5: assert property (@(posedge clk) disable iff (rst)
        resp_err |-> (resp_rdata == '0));

    // R5: write strobe only for a requested write
    assert_we_only_write_R5: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (xfer_valid && xfer_kind == 2'b01));

    // R7: a bus fault always comes with the event latched
    assert_busfault_event_R7: assert property (@(posedge clk) disable iff (rst)
        bus_fault |-> acc_evt);

    // R10: the event holds unless software cleared it
    assert_event_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(acc_evt) && !$past(evt_clear_wr)) |-> acc_evt);

    // R11: interrupt only follows a latched event
    assert_irq_follows_R11: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(acc_evt));

    // R12: fault pulses answer a request of the previous cycle
    assert_pulse_phase_R12: assert property (@(posedge clk) disable iff (rst)
        (sec_fault || bus_fault || resp_err) |-> $past(xfer_valid));

endmodule

bind rgn_guard rgn_guard_chk #(
    .DATA_W (DATA_W),
    .RA_W   (RA_W),
    .NREG   (1 << RIDX_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .xfer_valid (xfer_valid),
    .xfer_kind  (xfer_kind),
    .mem_we     (mem_we),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .resp_err   (resp_err),
    .resp_rdata (resp_rdata),
    .sec_fault  (sec_fault),
    .bus_fault  (bus_fault),
    .acc_evt    (acc_evt),
    .irq        (irq)
);

// File: tb/rgn_guard_tb.sv
module rgn_guard_tb;
    localparam int RIDX_W = 6;
    localparam int NREG   = 1 << RIDX_W;
    localparam int SHIFT  = 14;
    localparam int ADDR_W = SHIFT + RIDX_W;
    localparam int RA_W   = RIDX_W + 1;
    localparam int IDX_EVT = NREG;
    localparam int IDX_IE  = NREG + 1;
    localparam int IDX_SET = NREG + 2;
    localparam int IDX_CLR = NREG + 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_wr = 1'b0;
    logic [RA_W-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic xfer_valid = 1'b0;
    logic [ADDR_W-1:0] xfer_addr = '0;
    logic [1:0] xfer_kind = 2'b00;
    logic xfer_secure = 1'b0;
    logic xfer_cpu = 1'b0;
    logic xfer_allow, mem_re, mem_we;
    logic [31:0] mem_rdata = '0;
    logic resp_valid, resp_err, sec_fault, bus_fault, acc_evt, irq;
    logic [31:0] resp_rdata;

    int checks = 0;
    int fails  = 0;
    logic [31:0] perm_m [NREG];
    logic evt_m = 1'b0;
    logic ie_m  = 1'b0;

    always #5 clk = ~clk;

    rgn_guard #(.RIDX_W(RIDX_W), .REGION_BYTES(16384), .DATA_W(32)) u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .xfer_valid(xfer_valid), .xfer_addr(xfer_addr),
        .xfer_kind(xfer_kind), .xfer_secure(xfer_secure), .xfer_cpu(xfer_cpu),
        .xfer_allow(xfer_allow), .mem_re(mem_re), .mem_we(mem_we), .mem_rdata(mem_rdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata), .resp_err(resp_err),
        .sec_fault(sec_fault), .bus_fault(bus_fault), .acc_evt(acc_evt), .irq(irq)
    );

    task automatic summary_and_end();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        summary_and_end();
    end

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mask_perm(input logic [31:0] w);
        return w & 32'h0000_0117;
    endfunction

    // expected verdict: {sec_viol, perm_viol}
    function automatic logic [1:0] judge(input int r, input logic [1:0] k, input logic s);
        logic [31:0] p;
        logic need;
        p = perm_m[r];
        need = (k == 2'b00) ? p[2] : (k == 2'b01) ? p[1] : p[0];
        return {p[4] & ~s, ~need};
    endfunction

    task automatic reg_write(input int idx, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = RA_W'(idx); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (idx < NREG) begin
            if (!perm_m[idx][8]) perm_m[idx] = mask_perm(d);
        end else if (idx == IDX_EVT) evt_m = d[0];
        else if (idx == IDX_IE) ie_m = d[0];
        else if (idx == IDX_SET && d[0]) ie_m = 1'b1;
        else if (idx == IDX_CLR && d[0]) ie_m = 1'b0;
    endtask

    task automatic reg_check(input int idx, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = RA_W'(idx);
        #1;
        chk(req, $sformatf("reg[%0d]", idx), reg_rdata, exp);
    endtask

    task automatic xfer(input int r, input logic [1:0] k, input logic s, input logic c,
                        input string req);
        logic [1:0] v;
        logic allow, any, sf, bf, es;
        logic [31:0] d;
        v = judge(r, k, s);
        allow = (v == 2'b00);
        any = ~allow;
        sf = c & v[1];
        bf = c & v[0] & ~v[1];
        es = c ? bf : any;
        d = $urandom;
        @(negedge clk);
        xfer_valid = 1'b1; xfer_kind = k; xfer_secure = s; xfer_cpu = c;
        xfer_addr = {RIDX_W'(r), SHIFT'($urandom)};
        #1;
        chk("R12", "no pulse in request cycle", {30'd0, sec_fault, bus_fault}, 32'd0);
        chk("R5", "mem_re", {31'd0, mem_re}, {31'd0, allow & (k != 2'b01)});
        chk("R5", "mem_we", {31'd0, mem_we}, {31'd0, allow & (k == 2'b01)});
        @(negedge clk);
        xfer_valid = 1'b0;
        mem_rdata = d;
        #1;
        chk("R12", "resp_valid", {31'd0, resp_valid}, 32'd1);
        chk(req, "resp_err", {31'd0, resp_err}, {31'd0, any});
        chk(c ? (v[1] ? "R6" : "R7") : "R8", "sec_fault", {31'd0, sec_fault}, {31'd0, sf});
        chk(v == 2'b11 ? "R9" : "R7", "bus_fault", {31'd0, bus_fault}, {31'd0, bf});
        if (k != 2'b01) chk("R5", "resp_rdata", resp_rdata, allow ? d : 32'd0);
        if (es) evt_m = 1'b1;
        chk(req, "acc_evt", {31'd0, acc_evt}, {31'd0, evt_m});
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < NREG; i++) perm_m[i] = 32'h17;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        reg_check(0, 32'h17, "R1");
        reg_check(NREG - 1, 32'h17, "R1");
        reg_check(IDX_EVT, 32'h0, "R1");
        reg_check(IDX_IE, 32'h0, "R1");
        chk("R1", "irq", {31'd0, irq}, 32'd0);

        // R2 fetch governed by execute only; region 3 execute-only, non-secure
        reg_write(3, 32'h01);
        reg_check(3, 32'h01, "R2");
        xfer(3, 2'b10, 1'b0, 1'b1, "R2");
        xfer(3, 2'b11, 1'b0, 1'b0, "R2");
        xfer(3, 2'b00, 1'b0, 1'b0, "R2");
        xfer(3, 2'b01, 1'b1, 1'b1, "R2");

        // R3 secure region vs attribute
        reg_write(IDX_EVT, 32'h0);
        xfer(4, 2'b00, 1'b1, 1'b0, "R3");
        xfer(4, 2'b00, 1'b0, 1'b0, "R3");

        // R6 / R9 precedence; region 6 secure with no permissions
        reg_write(IDX_EVT, 32'h0);
        reg_write(6, 32'h10);
        xfer(6, 2'b00, 1'b0, 1'b1, "R9");
        chk("R9", "no event on secure fault", {31'd0, acc_evt}, 32'd0);
        xfer(4, 2'b01, 1'b0, 1'b1, "R6");
        xfer(6, 2'b00, 1'b1, 1'b1, "R7");

        // R10 collision: violation and clear in one cycle
        @(negedge clk);
        xfer_valid = 1'b1; xfer_kind = 2'b00; xfer_secure = 1'b0; xfer_cpu = 1'b0;
        xfer_addr = {RIDX_W'(6), SHIFT'(0)};
        reg_wr = 1'b1; reg_addr = RA_W'(IDX_EVT); reg_wdata = 32'h0;
        @(negedge clk);
        xfer_valid = 1'b0; reg_wr = 1'b0;
        #1;
        chk("R10", "set wins over clear", {31'd0, acc_evt}, 32'd1);
        chk("R8", "non-cpu no fault", {30'd0, sec_fault, bus_fault}, 32'd0);
        evt_m = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk("R10", "event sticky", {31'd0, acc_evt}, 32'd1);
        reg_write(IDX_EVT, 32'h0);
        #1;
        chk("R10", "clear alone", {31'd0, acc_evt}, 32'd0);

        // R11 interrupt enable handling
        reg_write(IDX_SET, 32'h1);
        reg_check(IDX_CLR, 32'h1, "R11");
        xfer(6, 2'b10, 1'b1, 1'b0, "R8");
        chk("R11", "irq one cycle late", {31'd0, irq}, 32'd0);
        @(negedge clk); #1;
        chk("R11", "irq raised", {31'd0, irq}, 32'd1);
        reg_write(IDX_CLR, 32'h1);
        @(negedge clk); #1;
        chk("R11", "irq dropped", {31'd0, irq}, 32'd0);
        reg_write(IDX_IE, 32'h1);
        reg_write(IDX_SET, 32'h0);
        reg_check(IDX_IE, 32'h1, "R11");
        reg_write(IDX_IE, 32'h0);
        reg_write(IDX_EVT, 32'h0);

        // R4 lock
        reg_write(5, 32'h117);
        reg_write(5, 32'h000);
        reg_check(5, 32'h117, "R4");
        xfer(5, 2'b01, 1'b1, 1'b1, "R4");

        // mixed random traffic
        for (int it = 0; it < 400; it++) begin
            int sel;
            sel = $urandom % 16;
            if (sel < 2) begin
                logic [31:0] w;
                int r;
                r = $urandom % NREG;
                w = $urandom;
                w[8] = (($urandom % 12) == 0);
                reg_write(r, w);
                reg_check(r, perm_m[r], "R4");
            end else if (sel == 2) begin
                reg_write(IDX_EVT, 32'h0);
            end else begin
                xfer($urandom % NREG, 2'($urandom), 1'($urandom), 1'($urandom), "R2");
            end
        end

        summary_and_end();
    end

endmodule